// File: doc/BRIEF.md
# Instruction Address Sequencer

This block is the register in a CPU front end that always names the byte address where the next instruction starts. When the fetch stage reports that it has taken an instruction, the register moves forward by the length of that instruction, which can be 2, 4 or 6 bytes. A branch or jump replaces the value with a target address. A call does the same and also returns the address that was about to be fetched, so the caller can store it as the return point.

Every value the register takes is cut to the width of the active addressing mode, which is 24, 31 or 64 bits. Sequential advance therefore wraps at the top of the current address space. On an interrupt the surrounding logic reads the address and the mode as one field of the saved status word. On return it writes both back through a restore request. All updates happen on the rising clock edge, and every output is a register.

Top module: `iaddr_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the address loads `rstVec` with bits 63..24 cleared and the mode becomes 24-bit (`curMode` = 2'b00). `lenErr`, `specErr` and `linkValid` are low after that edge.
- R2: An accepted fetch advances the address by the instruction length. `fetchIlc` 2'b01 means 2 bytes, 2'b10 means 4 bytes and 2'b11 means 6 bytes.
- R3: A fetch with `fetchIlc` = 2'b00 leaves the address unchanged and raises `lenErr` for exactly the cycle after the edge.
- R4: A branch whose target has bit 0 clear loads that target, masked to the active mode.
- R5: A branch whose target has bit 0 set leaves the address unchanged, produces no link, and raises `specErr` for the cycle after the edge.
- R6: An accepted branch with `branchCall` high pulses `linkValid` for one cycle. During that cycle `linkAddr` holds the address as it stood before the call.
- R7: Mode codes are 2'b00 for 24 bits, 2'b01 for 31 bits and 2'b10 for 64 bits. Every new address is zeroed above bit 23 in 24-bit mode and above bit 30 in 31-bit mode, and wraps modulo 2^64 in 64-bit mode.
- R8: A restore loads both the mode and the address, with the address masked to the new mode. A restore with mode code 2'b11 changes nothing and raises `specErr`.
- R9: When several requests meet in one cycle, only the highest one acts: reset first, then restore, then branch or call, then fetch. Losing requests have no effect and raise no flag.
- R10: With no request present, the address and the mode hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rstVec | input | 64 | Start address loaded on reset |
| fetchValid | input | 1 | An instruction was fetched this cycle |
| fetchIlc | input | 2 | Length code of the fetched instruction |
| branchValid | input | 1 | Branch or call request |
| branchCall | input | 1 | The branch request is a call |
| branchTarget | input | 64 | Branch or call destination |
| restoreValid | input | 1 | Reload from a saved status word |
| restoreAddr | input | 64 | Address field of the saved status word |
| restoreMode | input | 2 | Mode field of the saved status word |
| nextAddr | output | 64 | Address of the next instruction; the value to save on an interrupt |
| curMode | output | 2 | Active addressing mode; the value to save on an interrupt |
| linkAddr | output | 64 | Return address produced by a call |
| linkValid | output | 1 | `linkAddr` is fresh this cycle |
| lenErr | output | 1 | Invalid length code seen on the previous edge |
| specErr | output | 1 | Odd target or reserved mode seen on the previous edge |

## Verification
The bench sets the address just below each mode's wrap point by restore and then fetches every length code. A design that masked only on branch, or used the wrong bit boundary, would leave stray high bits or fail to wrap. Odd and even targets are tried in every mode, with and without the call flag. A wrong parity test would jump to an odd address, and a link taken after the load would return the target instead of the old address. Stacked requests are driven together: restore with branch, odd branch under restore, bad-length fetch under branch, and reset under restore. A broken priority chain shows up there as the wrong winner or as a flag raised by a request that lost.

// File: rtl/iaddr_pkg.sv
package iaddr_pkg;
  localparam int ADDR_W  = 64;
  localparam int NARROW_W = 24;
  localparam int MID_W    = 31;
  localparam int NUM_MODES = 3;

  typedef enum logic [1:0] {
    MODE24 = 2'b00,
    MODE31 = 2'b01,
    MODE64 = 2'b10
  } amode_e;

  localparam logic [1:0] MODE_RSVD = 2'b11;

  typedef struct packed {
    logic ldReset;
    logic ldRestore;
    logic ldBranch;
    logic ldInc;
    logic saveLink;
    logic flagLen;
    logic flagSpec;
  } strobe_t;

  function automatic int modeWidth(input int m);
    case (m)
      0:       return NARROW_W;
      1:       return MID_W;
      default: return ADDR_W;
    endcase
  endfunction
endpackage

// File: rtl/iaddr_ctrl.sv
module iaddr_ctrl
  import iaddr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restoreValid,
  input  logic [1:0] restoreMode,
  input  logic       branchValid,
  input  logic       branchCall,
  input  logic       tgtLsb,
  input  logic       fetchValid,
  input  logic [1:0] fetchIlc,
  output strobe_t    strb,
  output logic       lenErr,
  output logic       specErr
);
  always_comb begin
    strb = '0;
    if (rst) begin
      strb.ldReset = 1'b1;
    end else if (restoreValid) begin
      if (restoreMode != MODE_RSVD) strb.ldRestore = 1'b1;
      else                          strb.flagSpec  = 1'b1;
    end else if (branchValid) begin
      if (!tgtLsb) begin
        strb.ldBranch = 1'b1;
        strb.saveLink = branchCall;
      end else begin
        strb.flagSpec = 1'b1;
      end
    end else if (fetchValid) begin
      if (fetchIlc != 2'b00) strb.ldInc   = 1'b1;
      else                   strb.flagLen = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lenErr  <= 1'b0;
      specErr <= 1'b0;
    end else begin
      lenErr  <= strb.flagLen;
      specErr <= strb.flagSpec;
    end
  end

  // R3
  len_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    lenErr |-> $past(fetchValid && fetchIlc == 2'b00 && !restoreValid && !branchValid));

  // R5 R8 R9
  spec_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    specErr |-> $past((restoreValid && restoreMode == MODE_RSVD) ||
                      (!restoreValid && branchValid && tgtLsb)));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(lenErr && specErr));
endmodule

// File: rtl/iaddr_dp.sv
module iaddr_dp
  import iaddr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strb,
  input  logic [AW-1:0] rstVec,
  input  logic [AW-1:0] restoreAddr,
  input  logic [1:0]    restoreMode,
  input  logic [AW-1:0] target,
  input  logic [1:0]    fetchIlc,
  output logic [AW-1:0] pc,
  output logic [1:0]    mode,
  output logic [AW-1:0] linkAddr,
  output logic          linkValid
);
  logic [AW-1:0] widthMask [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mask
    localparam int MW = modeWidth(g);
    if (MW >= AW) begin : g_full
      assign widthMask[g] = '1;
    end else begin : g_part
      assign widthMask[g] = {{(AW-MW){1'b0}}, {MW{1'b1}}};
    end
  end

  logic [AW-1:0] stepBytes;
  logic [AW-1:0] seqAddr;
  logic [AW-1:0] activeMask;
  logic [AW-1:0] restoreMask;

  assign stepBytes   = {{(AW-3){1'b0}}, fetchIlc, 1'b0};
  assign seqAddr     = pc + stepBytes;
  assign activeMask  = (mode == MODE_RSVD) ? widthMask[0] : widthMask[mode];
  assign restoreMask = (restoreMode == MODE_RSVD) ? widthMask[0] : widthMask[restoreMode];

  always_ff @(posedge clk) begin
    if (strb.ldReset) begin
      pc        <= rstVec & widthMask[0];
      mode      <= MODE24;
      linkValid <= 1'b0;
      linkAddr  <= '0;
    end else begin
      linkValid <= strb.saveLink;
      if (strb.saveLink) linkAddr <= pc;
      if (strb.ldRestore) begin
        pc   <= restoreAddr & restoreMask;
        mode <= restoreMode;
      end else if (strb.ldBranch) begin
        pc <= target & activeMask;
      end else if (strb.ldInc) begin
        pc <= seqAddr & activeMask;
      end
    end
  end

  // R7
  mask24_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE24 |-> pc[AW-1:NARROW_W] == '0);

  // R7
  mask31_chk: assert property (@(posedge clk) disable iff (rst)
    mode == MODE31 |-> pc[AW-1:MID_W] == '0);

  // R8
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != MODE_RSVD);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(strb.ldRestore || strb.ldBranch || strb.ldInc) |=> $stable(pc) && $stable(mode));

  // R6
  link_chk: assert property (@(posedge clk) disable iff (rst)
    strb.saveLink |=> linkValid && linkAddr == $past(pc));
endmodule

// File: rtl/iaddr_reg.sv
module iaddr_reg
  import iaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rstVec,
  input  logic              fetchValid,
  input  logic [1:0]        fetchIlc,
  input  logic              branchValid,
  input  logic              branchCall,
  input  logic [ADDR_W-1:0] branchTarget,
  input  logic              restoreValid,
  input  logic [ADDR_W-1:0] restoreAddr,
  input  logic [1:0]        restoreMode,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [1:0]        curMode,
  output logic [ADDR_W-1:0] linkAddr,
  output logic              linkValid,
  output logic              lenErr,
  output logic              specErr
);
  strobe_t strb;

  iaddr_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .restoreValid (restoreValid),
    .restoreMode  (restoreMode),
    .branchValid  (branchValid),
    .branchCall   (branchCall),
    .tgtLsb       (branchTarget[0]),
    .fetchValid   (fetchValid),
    .fetchIlc     (fetchIlc),
    .strb         (strb),
    .lenErr       (lenErr),
    .specErr      (specErr)
  );

  iaddr_dp #(.AW(ADDR_W)) i_dp (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .rstVec      (rstVec),
    .restoreAddr (restoreAddr),
    .restoreMode (restoreMode),
    .target      (branchTarget),
    .fetchIlc    (fetchIlc),
    .pc          (nextAddr),
    .mode        (curMode),
    .linkAddr    (linkAddr),
    .linkValid   (linkValid)
  );
endmodule

// File: tb/test_iaddr_reg.sv
module test_iaddr_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] rstVec;
  logic        fetchValid;
  logic [1:0]  fetchIlc;
  logic        branchValid;
  logic        branchCall;
  logic [63:0] branchTarget;
  logic        restoreValid;
  logic [63:0] restoreAddr;
  logic [1:0]  restoreMode;
  logic [63:0] nextAddr;
  logic [1:0]  curMode;
  logic [63:0] linkAddr;
  logic        linkValid;
  logic        lenErr;
  logic        specErr;

  int checks = 0;
  int errors = 0;
  logic [63:0] mPc;
  logic [1:0]  mMode;

  always #2 clk = ~clk;

  iaddr_reg i_iaddr_reg (
    .clk(clk), .rst(rst), .rstVec(rstVec),
    .fetchValid(fetchValid), .fetchIlc(fetchIlc),
    .branchValid(branchValid), .branchCall(branchCall), .branchTarget(branchTarget),
    .restoreValid(restoreValid), .restoreAddr(restoreAddr), .restoreMode(restoreMode),
    .nextAddr(nextAddr), .curMode(curMode), .linkAddr(linkAddr), .linkValid(linkValid),
    .lenErr(lenErr), .specErr(specErr)
  );

  function automatic logic [63:0] bmask(input logic [63:0] v, input logic [1:0] m);
    if (m == 2'b00) return v & 64'h0000_0000_00FF_FFFF;
    if (m == 2'b01) return v & 64'h0000_0000_7FFF_FFFF;
    return v;
  endfunction

  function automatic logic [63:0] lenOf(input logic [1:0] c);
    case (c)
      2'b01:   return 64'd2;
      2'b10:   return 64'd4;
      2'b11:   return 64'd6;
      default: return 64'd0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic apply(input logic r, input logic rv, input logic [63:0] ra, input logic [1:0] rm,
                       input logic bv, input logic bc, input logic [63:0] bt,
                       input logic fv, input logic [1:0] fi, input string req);
    logic eLen = 1'b0;
    logic eSpec = 1'b0;
    logic eLink = 1'b0;
    logic [63:0] eLinkAddr = '0;
    rst = r; restoreValid = rv; restoreAddr = ra; restoreMode = rm;
    branchValid = bv; branchCall = bc; branchTarget = bt;
    fetchValid = fv; fetchIlc = fi;
    if (r) begin
      mPc = bmask(rstVec, 2'b00); mMode = 2'b00;
    end else if (rv) begin
      if (rm != 2'b11) begin mMode = rm; mPc = bmask(ra, rm); end
      else eSpec = 1'b1;
    end else if (bv) begin
      if (!bt[0]) begin
        if (bc) begin eLink = 1'b1; eLinkAddr = mPc; end
        mPc = bmask(bt, mMode);
      end else eSpec = 1'b1;
    end else if (fv) begin
      if (fi != 2'b00) mPc = bmask(mPc + lenOf(fi), mMode);
      else eLen = 1'b1;
    end
    @(negedge clk);
    chk(req, "nextAddr", nextAddr, mPc);
    chk(req, "curMode", {62'd0, curMode}, {62'd0, mMode});
    chk(req, "lenErr", {63'd0, lenErr}, {63'd0, eLen});
    chk(req, "specErr", {63'd0, specErr}, {63'd0, eSpec});
    chk(req, "linkValid", {63'd0, linkValid}, {63'd0, eLink});
    if (eLink) chk(req, "linkAddr", linkAddr, eLinkAddr);
    rst = 1'b0; restoreValid = 1'b0; branchValid = 1'b0; branchCall = 1'b0; fetchValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] bases [5];
    logic [63:0] tgts [4];
    bases[0] = 64'h0; bases[1] = 64'h0000_0000_00FF_FFFC; bases[2] = 64'h0000_0000_7FFF_FFFE;
    bases[3] = 64'hFFFF_FFFF_FFFF_FFFA; bases[4] = 64'h1234_5678_9ABC_DEF0;
    tgts[0] = 64'hFFFF_FFFF_FFFF_FFF0; tgts[1] = 64'h0000_0000_8123_4566;
    tgts[2] = 64'h0000_0000_0000_0101; tgts[3] = 64'hABCD_0000_00F0_0002;
    rstVec = 64'hABCD_1234_5678_9ABE;
    rst = 1'b1; restoreValid = 1'b0; restoreAddr = '0; restoreMode = '0;
    branchValid = 1'b0; branchCall = 1'b0; branchTarget = '0; fetchValid = 1'b0; fetchIlc = '0;
    mPc = '0; mMode = '0;

    // R1 reset state
    apply(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R10 idle hold
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");

    // R2 R3 R7 R8 sweep: restore near wrap points then fetch each length code
    for (int m = 0; m < 3; m++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 4; c++) begin
          apply(0, 1, bases[b], 2'(m), 0, 0, 0, 0, 0, "R8");
          apply(0, 0, 0, 0, 0, 0, 0, 1, 2'(c), (c == 0) ? "R3" : "R2 R7");
          apply(0, 0, 0, 0, 0, 0, 0, 1, 2'(c), (c == 0) ? "R3" : "R2 R7");
        end

    // R4 R5 R6 R7 branches and calls in every mode
    for (int m = 0; m < 3; m++)
      for (int t = 0; t < 4; t++)
        for (int k = 0; k < 2; k++) begin
          apply(0, 1, 64'h0000_0000_0012_3450, 2'(m), 0, 0, 0, 0, 0, "R8");
          apply(0, 0, 0, 0, 1, k[0], tgts[t], 0, 0,
                tgts[t][0] ? "R5" : (k == 1 ? "R6 R4" : "R4 R7"));
          apply(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 R10");
        end

    // R8 reserved mode rejected
    apply(0, 1, 64'h0000_0000_0000_8000, 2'b10, 0, 0, 0, 0, 0, "R8");
    apply(0, 1, 64'h5555_0000_0000_0000, 2'b11, 0, 0, 0, 0, 0, "R8");

    // R9 priority combinations
    apply(0, 1, 64'h0000_0000_0000_4000, 2'b01, 1, 1, 64'h0000_0000_0000_0200, 1, 2'b11, "R9");
    apply(0, 1, 64'h0000_0000_0000_6000, 2'b10, 1, 1, 64'h0000_0000_0000_0201, 0, 0, "R9");
    apply(0, 0, 0, 0, 1, 0, 64'h0000_0000_0000_0300, 1, 2'b00, "R9");
    apply(0, 0, 0, 0, 1, 1, 64'h0000_0000_0000_0401, 1, 2'b10, "R9 R5");
    apply(1, 1, 64'h0000_0000_0000_0800, 2'b10, 1, 1, 64'h0000_0000_0000_0900, 1, 2'b01, "R1 R9");
    apply(0, 0, 0, 0, 0, 0, 0, 1, 2'b10, "R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule